// File: doc/BRIEF.md
# Timer interrupt flag register

This block keeps the four interrupt flags of a 16-bit timer/counter in one 8-bit status byte. The counter datapath around it supplies per-cycle event strobes: a capture at the capture input, TOP reached, a match on compare channel A or B, and an overflow. A separate overflow strobe covers modes whose overflow point depends on the mode. It also supplies the forced-compare strobes, a 4-bit waveform-mode code and a timer-clock enable that marks prescaled timer ticks. The block turns these strobes into sticky flags and drives one interrupt request line per flag.

A flag clears in two ways. The interrupt controller can acknowledge it with a one-cycle pulse when the vector runs, or software can write a one to the flag's bit over a simple register bus. The bus read data is the flag byte, built from register outputs only. The compare flags rise one timer tick after the match. The capture flag and the overflow flag take their set event from a source that the waveform mode selects.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every flag, the read byte and every interrupt request are zero.
- R2: Flags occupy read-byte bits 0 (overflow), 1 (compare A), 2 (compare B) and 5 (capture). Bits 3, 4, 6 and 7 always read zero, and writes to them have no effect.
- R3: A compare match strobe on channel A (or B) in a cycle with the timer-clock enable high sets that compare flag at the next enabled timer tick. In the cycle right after the match tick, the flag still reads zero.
- R4: A match that arrives in the same cycle as that channel's forced-compare strobe does not set the flag. A forced-compare strobe on its own never sets the flag.
- R5: While the timer-clock enable is low, a pending compare match is held. The flag rises only on the next cycle with the enable high.
- R6: For wave_mode codes other than 8, 10, 12 and 14, the capture flag sets on the capture strobe, and the TOP strobe has no effect on it.
- R7: For wave_mode codes 8, 10, 12 and 14 (capture register used as TOP), the capture flag sets on the TOP strobe, and the capture strobe has no effect on it.
- R8: For wave_mode codes 0, 4 and 12, the overflow flag sets on the counter overflow strobe. For all other codes it sets on the mode-dependent overflow strobe, and the unused strobe is ignored.
- R9: An acknowledge pulse on a flag's bit (ack bit 0 overflow, 1 compare A, 2 compare B, 3 capture) clears that flag on the next edge.
- R10: A bus write with a one at a flag's bit position clears that flag. A zero at that position leaves the flag unchanged.
- R11: When a set event and a clear (acknowledge or write-one) for the same flag fall in the same cycle, the flag ends up set.
- R12: Each interrupt request bit equals its flag ANDed with the matching enable bit, using the ack bit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable, high on prescaled timer ticks |
| wave_mode | input | 4 | Waveform-mode code |
| ev_capture | input | 1 | Capture event at the capture input |
| ev_top | input | 1 | Counter reached TOP |
| ev_cmp_a | input | 1 | Counter equals compare register A |
| ev_cmp_b | input | 1 | Counter equals compare register B |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| ev_overflow | input | 1 | Counter overflow strobe |
| ev_mode_ovf | input | 1 | Mode-dependent overflow strobe |
| ack | input | 4 | Interrupt acknowledge pulses, one per flag |
| irq_en | input | 4 | Interrupt enables, one per flag |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data, ones clear flags |
| bus_rdata | output | 8 | Flag byte |
| irq | output | 4 | Interrupt requests |

## Verification
The compare path is driven in four patterns. A plain match with the timer enable held high shows that the flag is one tick late. A match with the enable then held low shows that it waits for a real tick. A match paired with its forced strobe, and a forced strobe alone, show that forcing is suppressed. The capture and overflow flags are driven with both candidate strobes under several mode codes, which shows that the mode picks the source. The clear patterns cover acknowledge, write-one, write-zero, writes to reserved bits and a set that collides with a clear. Those patterns show that clearing is per bit and that set has priority. Changing the enable mask against fixed flags shows that the request gating is independent per line.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

  localparam int NFLAG  = 4;
  localparam int BUS_W  = 8;
  localparam int MODE_W = 4;
  localparam int NCMP   = 2;

  // flag vector indices (also ack / irq / irq_en order)
  localparam int IDX_OVF  = 0;
  localparam int IDX_CMPA = 1;
  localparam int IDX_CMPB = 2;
  localparam int IDX_CAP  = 3;

  typedef logic [NFLAG-1:0]  flag_vec_t;
  typedef logic [MODE_W-1:0] mode_t;

  // bit position of each flag in the bus byte
  function automatic int flag_pos(input int idx);
    case (idx)
      IDX_OVF:  flag_pos = 0;
      IDX_CMPA: flag_pos = 1;
      IDX_CMPB: flag_pos = 2;
      default:  flag_pos = 5;
    endcase
  endfunction

  // capture register acts as TOP: codes 8, 10, 12, 14
  function automatic logic mode_cap_top(input mode_t m);
    mode_cap_top = m[3] & ~m[0];
  endfunction

  // counter overflow drives overflow flag: codes 0, 4, 12
  function automatic logic mode_plain_ovf(input mode_t m);
    mode_plain_ovf = (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
  endfunction

endpackage

// File: rtl/tmr_cmp_delay.sv
module tmr_cmp_delay
  import tmr_flag_pkg::*;
#(
  parameter int NCH = NCMP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic [NCH-1:0] match_i,
  input  logic [NCH-1:0] force_i,
  output logic [NCH-1:0] set_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pend_q;
    logic pend_d;

    // a match tick arms the channel, unless forced in the same cycle
    always_comb begin
      pend_d = pend_q;
      if (tick_en) begin
        pend_d = match_i[c] & ~force_i[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
      end
    end

    // flag set on the timer tick that follows the match tick
    assign set_o[c] = pend_q & tick_en;
  end

endmodule

// File: rtl/tmr_flag_src.sv
module tmr_flag_src
  import tmr_flag_pkg::*;
(
  input  mode_t           wave_mode,
  input  logic            ev_capture,
  input  logic            ev_top,
  input  logic            ev_overflow,
  input  logic            ev_mode_ovf,
  input  logic [NCMP-1:0] cmp_set,
  output flag_vec_t       set_vec
);

  logic cap_sel;
  logic ovf_sel;

  always_comb begin
    cap_sel = mode_cap_top(wave_mode) ? ev_top : ev_capture;
    ovf_sel = mode_plain_ovf(wave_mode) ? ev_overflow : ev_mode_ovf;
    set_vec           = '0;
    set_vec[IDX_OVF]  = ovf_sel;
    set_vec[IDX_CMPA] = cmp_set[0];
    set_vec[IDX_CMPB] = cmp_set[1];
    set_vec[IDX_CAP]  = cap_sel;
  end

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // set has priority over clear so no event is dropped
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic             ev_capture,
  input  logic             ev_top,
  input  logic             ev_cmp_a,
  input  logic             ev_cmp_b,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             ev_overflow,
  input  logic             ev_mode_ovf,
  input  logic [NFLAG-1:0] ack,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NFLAG-1:0] irq
);

  logic [NCMP-1:0] cmp_set;
  flag_vec_t       set_vec;
  flag_vec_t       clr_vec;
  flag_vec_t       flags;

  tmr_cmp_delay #(.NCH(NCMP)) u_cmp_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .match_i ({ev_cmp_b, ev_cmp_a}),
    .force_i ({force_b, force_a}),
    .set_o   (cmp_set)
  );

  tmr_flag_src u_flag_src (
    .wave_mode   (wave_mode),
    .ev_capture  (ev_capture),
    .ev_top      (ev_top),
    .ev_overflow (ev_overflow),
    .ev_mode_ovf (ev_mode_ovf),
    .cmp_set     (cmp_set),
    .set_vec     (set_vec)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = flag_pos(i);

    assign clr_vec[i] = ack[i] | (bus_wr & bus_wdata[POS]);

    tmr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_o (flags[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NFLAG; i++) begin
      bus_rdata[flag_pos(i)] = flags[i];
    end
  end

  assign irq = flags & irq_en;

endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tmr_flag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [MODE_W-1:0] wave_mode,
  input logic             ev_capture,
  input logic             ev_cmp_a,
  input logic             force_a,
  input logic             ev_overflow,
  input logic             ev_mode_ovf,
  input logic [NFLAG-1:0] ack,
  input logic [NFLAG-1:0] irq_en,
  input logic             bus_wr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [NFLAG-1:0] irq
);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[7:6] == 2'b00) && (bus_rdata[4:3] == 2'b00));

  // R3
  cmpa_late_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ev_cmp_a && !force_a) ##1 tick_en |=> bus_rdata[1]);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !ev_overflow && !ev_mode_ovf) |=> !bus_rdata[0]);

  // R10
  zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[0] && !ack[0] && !(bus_wr && bus_wdata[0])) |=> bus_rdata[0]);

  // R11
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !mode_cap_top(wave_mode) && ack[3] && bus_wr && bus_wdata[5])
      |=> bus_rdata[5]);

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ({bus_rdata[5], bus_rdata[2], bus_rdata[1], bus_rdata[0]} & irq_en));

endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .wave_mode   (wave_mode),
  .ev_capture  (ev_capture),
  .ev_cmp_a    (ev_cmp_a),
  .force_a     (force_a),
  .ev_overflow (ev_overflow),
  .ev_mode_ovf (ev_mode_ovf),
  .ack         (ack),
  .irq_en      (irq_en),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq         (irq)
);

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       tick;
    logic [3:0] mode;
    logic       cap;
    logic       top;
    logic       ma;
    logic       mb;
    logic       fa;
    logic       fb;
    logic       ov;
    logic       mov;
    logic [3:0] ack;
    logic [3:0] en;
    logic       wr;
    logic [7:0] wd;
  } stim_t;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic [3:0] wave_mode;
  logic       ev_capture, ev_top, ev_cmp_a, ev_cmp_b;
  logic       force_a, force_b, ev_overflow, ev_mode_ovf;
  logic [3:0] ack, irq_en, irq;
  logic       bus_wr;
  logic [7:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  // reference state built from the requirements
  logic [3:0] m_flag;
  logic       m_pa, m_pb;

  tmr_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wave_mode(wave_mode),
    .ev_capture(ev_capture), .ev_top(ev_top), .ev_cmp_a(ev_cmp_a),
    .ev_cmp_b(ev_cmp_b), .force_a(force_a), .force_b(force_b),
    .ev_overflow(ev_overflow), .ev_mode_ovf(ev_mode_ovf), .ack(ack),
    .irq_en(irq_en), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic stim_t idle();
    stim_t s;
    s = '0;
    s.tick = 1'b1;
    s.en = 4'hF;
    return s;
  endfunction

  function automatic logic [7:0] byte_of(input logic [3:0] f);
    return {2'b00, f[3], 2'b00, f[2], f[1], f[0]};
  endfunction

  // driver: apply one cycle and push the expected outcome
  task automatic drive(input stim_t s, input string tag);
    logic [3:0] setv, clrv;
    logic cap_top, plain_ovf;
    @(negedge clk);
    tick_en = s.tick; wave_mode = s.mode; ev_capture = s.cap; ev_top = s.top;
    ev_cmp_a = s.ma; ev_cmp_b = s.mb; force_a = s.fa; force_b = s.fb;
    ev_overflow = s.ov; ev_mode_ovf = s.mov; ack = s.ack; irq_en = s.en;
    bus_wr = s.wr; bus_wdata = s.wd;
    cap_top   = s.mode inside {4'd8, 4'd10, 4'd12, 4'd14};
    plain_ovf = s.mode inside {4'd0, 4'd4, 4'd12};
    setv[3] = cap_top ? s.top : s.cap;
    setv[0] = plain_ovf ? s.ov : s.mov;
    setv[1] = s.tick & m_pa;
    setv[2] = s.tick & m_pb;
    if (s.tick) begin
      m_pa = s.ma & ~s.fa;
      m_pb = s.mb & ~s.fb;
    end
    clrv = s.ack | (s.wr ? {s.wd[5], s.wd[2], s.wd[1], s.wd[0]} : 4'h0);
    m_flag = setv | (m_flag & ~clrv);
    @(posedge clk);
    exp_q.push_back({byte_of(m_flag), m_flag & s.en});
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({bus_rdata, irq} !== e) begin
          errors++;
          $display("FAIL %s rdata=%h exp=%h irq=%b exp=%b",
                   t, bus_rdata, e[11:4], irq, e[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    m_flag = '0; m_pa = 1'b0; m_pb = 1'b0;
    s = idle();
    tick_en = 1'b1; wave_mode = '0; ev_capture = 0; ev_top = 0;
    ev_cmp_a = 0; ev_cmp_b = 0; force_a = 0; force_b = 0;
    ev_overflow = 0; ev_mode_ovf = 0; ack = '0; irq_en = 4'hF;
    bus_wr = 0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h00 || irq !== 4'h0) begin
      errors++;
      $display("FAIL R1 rdata=%h exp=00 irq=%b exp=0000", bus_rdata, irq);
    end
    rst_n = 1'b1;

    // R1 idle after reset
    drive(idle(), "R1");
    // R2 reserved bits ignore writes
    s = idle(); s.wr = 1; s.wd = 8'hFF; drive(s, "R2");
    // R3 compare A and B, one tick late
    s = idle(); s.ma = 1; drive(s, "R3");
    drive(idle(), "R3");
    s = idle(); s.mb = 1; drive(s, "R3");
    drive(idle(), "R3");
    s = idle(); s.wr = 1; s.wd = 8'h06; drive(s, "R10");
    // R4 forced strobes
    s = idle(); s.ma = 1; s.fa = 1; drive(s, "R4");
    drive(idle(), "R4");
    s = idle(); s.fb = 1; drive(s, "R4");
    drive(idle(), "R4");
    // R5 tick gating
    s = idle(); s.ma = 1; drive(s, "R5");
    s = idle(); s.tick = 0; drive(s, "R5");
    s = idle(); s.tick = 0; drive(s, "R5");
    drive(idle(), "R5");
    s = idle(); s.ack = 4'b0010; drive(s, "R9");
    // R6 capture input source
    s = idle(); s.top = 1; drive(s, "R6");
    s = idle(); s.cap = 1; drive(s, "R6");
    s = idle(); s.ack = 4'b1000; drive(s, "R9");
    // R7 TOP source when capture register is TOP
    s = idle(); s.mode = 4'd12; s.cap = 1; drive(s, "R7");
    s = idle(); s.mode = 4'd14; s.top = 1; drive(s, "R7");
    s = idle(); s.wr = 1; s.wd = 8'h20; drive(s, "R10");
    // R8 overflow source
    s = idle(); s.mov = 1; drive(s, "R8");
    s = idle(); s.ov = 1; drive(s, "R8");
    s = idle(); s.ack = 4'b0001; drive(s, "R9");
    s = idle(); s.mode = 4'd5; s.ov = 1; drive(s, "R8");
    s = idle(); s.mode = 4'd5; s.mov = 1; drive(s, "R8");
    // R10 write zero keeps, write one clears
    s = idle(); s.wr = 1; s.wd = 8'h00; drive(s, "R10");
    s = idle(); s.wr = 1; s.wd = 8'hDE; drive(s, "R10");
    s = idle(); s.wr = 1; s.wd = 8'h01; drive(s, "R10");
    // R11 set wins over clear
    s = idle(); s.ov = 1; s.ack = 4'b0001; s.wr = 1; s.wd = 8'h01; drive(s, "R11");
    s = idle(); s.cap = 1; s.ack = 4'b1000; drive(s, "R11");
    // R12 request gating
    s = idle(); s.ma = 1; drive(s, "R12");
    s = idle(); s.en = 4'b0101; drive(s, "R12");
    s = idle(); s.en = 4'b1010; drive(s, "R12");
    s = idle(); s.en = 4'b0000; drive(s, "R12");
    drive(idle(), "R12");
    @(posedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule